// File: doc/BRIEF.md
# Sync-Counted Square-Wave Beep Generator

This block makes the warning beep of an audio codec. It has no oscillator of its own. It counts the frame sync strobes of the audio link, which arrive at 48 kHz, and derives a square wave from them. An 8-bit divider sets the pitch. The tone period is four times the divider, counted in sync strobes, so the pitch runs from roughly 47 Hz up to 12 kHz. A divider of zero switches the whole function off.

While a tone is playing, the block does three things:
- It gives every pin path that is set up as an output a select line, so that the path carries the beep sample.
- It mutes all other audio sources.
- In the low-power state, it withdraws its permission to stop the link clock, because the beep cannot run without that clock.

The sample is a signed full-scale code. It flips polarity with the square-wave phase and changes only on sync strobe boundaries. The block is used inside the codec's output mixing. Software programs the divider, and the power manager supplies the low-power indication.

Top module: `beep_tone_gen`

## Requirements
- R1: After reset, the block is in this state: `tone_sample` is 0, `mute_others` is 0, `clk_stop_ok` is 1, and no bit of `pin_beep_sel` is set.
- R2: With a nonzero divider D, the output sample follows a fixed pattern counted in sync strobes after the divider took effect. For strobes 1 through 2·D, the sample is +(2^(SAMPLE_W-1)−1). For strobes 2·D+1 through 4·D, it is −(2^(SAMPLE_W-1)−1). The pattern then repeats with a period of 4·D strobes.
- R3: While the divider is 0, sync strobes produce a sample of 0, and `mute_others` stays at 0.
- R4: `tone_sample` and `mute_others` change only on a clock edge where `frame_sync` is high.
- R5: Writing a new nonzero divider that differs from the current one restarts the count. The next strobe is strobe 1 of a fresh positive half-period. Any strobe in the same cycle as the write is ignored.
- R6: When the divider changes from nonzero to 0, the old sample and the mute both hold until the next strobe. On that strobe the sample becomes 0 and the mute is released together.
- R7: `clk_stop_ok` goes to 0 within two clock cycles when `low_power` is 1 and the divider is nonzero. Otherwise it is 1.
- R8: `pin_beep_sel[i]` equals `pin_out_en[i]` while `mute_others` is 1. It is 0 for every pin while `mute_others` is 0.
- R9: The internal strobe count never reaches 2·D while the block is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle strobe per 48 kHz frame |
| divider | input | DIV_W | Pitch divider; 0 disables |
| low_power | input | 1 | High while the codec is in its low-power state |
| pin_out_en | input | NPIN | One bit per pin path configured as output |
| tone_sample | output | SAMPLE_W | Signed beep sample |
| mute_others | output | 1 | Disables all other audio sources |
| clk_stop_ok | output | 1 | 0 forbids stopping the link clock |
| pin_beep_sel | output | NPIN | Pin paths that carry the beep |

## Verification
The hardest condition to reach from the ports is a divider change in the middle of a half-period. Only that case shows whether the counter and phase truly restart or just carry on. The stimulus reaches it by first advancing a tone a few strobes into each half. It then writes a different divider and checks that the next 2·D strobes are all positive. A full sweep over dividers 1 to 40, plus 128 and 255, runs past one complete period each time. This exposes off-by-one errors at both half-period edges.

// File: rtl/beep_pkg.sv
package beep_pkg;
  typedef enum logic {
    PH_POS = 1'b0,
    PH_NEG = 1'b1
  } beep_phase_e;
endpackage

// File: rtl/beep_div_reg.sv
module beep_div_reg #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] div_q_o,
  output logic             active_o,
  output logic             restart_o
);
  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    div_d     = div_i;
    restart_o = (div_i != div_q) && (div_i != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign div_q_o  = div_q;
  assign active_o = (div_q != '0);

  // R5: a restart always lands on a nonzero divider
  p_restart_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> active_o);
endmodule

// File: rtl/beep_phase_ctr.sv
module beep_phase_ctr
  import beep_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             active_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output beep_phase_e      phase_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, half_last;
  beep_phase_e      phase_q, phase_d;
  logic             cnt_en;

  always_comb begin
    half_last = {div_i, 1'b0} - CNT_W'(1);
    cnt_en    = restart_i || !active_i || sync_i;
    cnt_d     = cnt_q;
    phase_d   = phase_q;
    if (restart_i || !active_i) begin
      cnt_d   = '0;
      phase_d = PH_POS;
    end else if (sync_i) begin
      if (cnt_q == half_last) begin
        cnt_d   = '0;
        phase_d = (phase_q == PH_POS) ? PH_NEG : PH_POS;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_POS;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

  // R9: count stays inside one half-period
  p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (cnt_q < {div_i, 1'b0}));
  // R2: phase only flips on a strobe
  p_phase_on_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) && (phase_q == PH_NEG) |-> $past(sync_i));
endmodule

// File: rtl/beep_out_stage.sv
module beep_out_stage
  import beep_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int NPIN     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sync_i,
  input  logic                       active_i,
  input  beep_phase_e                phase_i,
  input  logic                       low_power_i,
  input  logic [NPIN-1:0]            pin_en_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       mute_o,
  output logic                       stop_ok_o,
  output logic [NPIN-1:0]            pin_sel_o
);
  localparam logic signed [SAMPLE_W-1:0] POS_FS = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] NEG_FS = -POS_FS;

  logic signed [SAMPLE_W-1:0] sample_q, sample_d;
  logic mute_q, mute_d, stop_ok_q, stop_ok_d;

  always_comb begin
    if (active_i) begin
      sample_d = (phase_i == PH_POS) ? POS_FS : NEG_FS;
      mute_d   = 1'b1;
    end else begin
      sample_d = '0;
      mute_d   = 1'b0;
    end
    stop_ok_d = !(low_power_i && active_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q  <= '0;
      mute_q    <= 1'b0;
      stop_ok_q <= 1'b1;
    end else begin
      stop_ok_q <= stop_ok_d;
      if (sync_i) begin
        sample_q <= sample_d;
        mute_q   <= mute_d;
      end
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pin_sel_o[i] = pin_en_i[i] & mute_q;
  end

  assign sample_o  = sample_q;
  assign mute_o    = mute_q;
  assign stop_ok_o = stop_ok_q;

  // R4: outputs move only on a strobe
  p_hold_between_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> $stable(sample_q) && $stable(mute_q));
  // R6: mute and nonzero sample always travel together
  p_mute_matches_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mute_q == (sample_q != '0));
endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen
  import beep_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int SAMPLE_W = 16,
  parameter int NPIN     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_sync,
  input  logic [DIV_W-1:0]           divider,
  input  logic                       low_power,
  input  logic [NPIN-1:0]            pin_out_en,
  output logic signed [SAMPLE_W-1:0] tone_sample,
  output logic                       mute_others,
  output logic                       clk_stop_ok,
  output logic [NPIN-1:0]            pin_beep_sel
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [DIV_W-1:0] div_q;
  logic             active, restart;
  beep_phase_e      phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  beep_div_reg #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .div_i(divider),
    .div_q_o(div_q), .active_o(active), .restart_o(restart)
  );

  beep_phase_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk(clk), .rst_n(rst_int_n), .sync_i(frame_sync),
    .active_i(active), .restart_i(restart), .div_i(div_q), .phase_o(phase)
  );

  beep_out_stage #(.SAMPLE_W(SAMPLE_W), .NPIN(NPIN)) u_out (
    .clk(clk), .rst_n(rst_int_n), .sync_i(frame_sync),
    .active_i(active), .phase_i(phase), .low_power_i(low_power),
    .pin_en_i(pin_out_en), .sample_o(tone_sample), .mute_o(mute_others),
    .stop_ok_o(clk_stop_ok), .pin_sel_o(pin_beep_sel)
  );

  // R7: permission is only withdrawn after a low-power cycle
  p_stop_needs_lowpwr_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !clk_stop_ok |-> $past(low_power));
  // R8: no pin carries the beep unless it is an output
  p_pin_sel_subset_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pin_beep_sel & ~pin_out_en) == '0);
endmodule

// File: tb/beep_tone_gen_tb.sv
module beep_tone_gen_tb;
  localparam int DIV_W = 8, SAMPLE_W = 16, NPIN = 4;
  localparam int POS = (1 << (SAMPLE_W-1)) - 1;
  localparam int NEG = -POS;

  logic clk = 1'b0, rst_n = 1'b0, frame_sync = 1'b0, low_power = 1'b0;
  logic [DIV_W-1:0] divider = '0;
  logic [NPIN-1:0]  pin_out_en = '0;
  logic signed [SAMPLE_W-1:0] tone_sample;
  logic mute_others, clk_stop_ok;
  logic [NPIN-1:0] pin_beep_sel;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  beep_tone_gen #(.DIV_W(DIV_W), .SAMPLE_W(SAMPLE_W), .NPIN(NPIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .divider(divider),
    .low_power(low_power), .pin_out_en(pin_out_en), .tone_sample(tone_sample),
    .mute_others(mute_others), .clk_stop_ok(clk_stop_ok), .pin_beep_sel(pin_beep_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse();
    @(negedge clk) frame_sync = 1'b1;
    @(negedge clk) frame_sync = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_div(input int d);
    @(negedge clk) divider = DIV_W'(d);
    repeat (3) @(negedge clk);
  endtask

  function automatic int exp_of(input int n, input int d);
    return (((n - 1) / (2 * d)) % 2 == 0) ? POS : NEG;
  endfunction

  task automatic run_tone(input int d, input int from_n, input int to_n);
    for (int n = from_n; n <= to_n; n++) begin
      pulse();
      chk("R2", int'(tone_sample), exp_of(n, d));
      chk("R2 mute", int'(mute_others), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 sample", int'(tone_sample), 0);
    chk("R1 mute", int'(mute_others), 0);
    chk("R1 stop_ok", int'(clk_stop_ok), 1);
    chk("R1 pins", int'(pin_beep_sel), 0);

    // R3 disabled divider ignores strobes
    pin_out_en = '1;
    for (int k = 0; k < 3; k++) begin
      pulse();
      chk("R3 sample", int'(tone_sample), 0);
      chk("R3 mute", int'(mute_others), 0);
      chk("R3 pins", int'(pin_beep_sel), 0);
    end

    // R2 sweep over dividers
    for (int d = 1; d <= 40; d++) begin
      set_div(d);
      run_tone(d, 1, 4 * d + 2);
    end
    set_div(128); run_tone(128, 1, 4 * 128 + 2);
    set_div(255); run_tone(255, 1, 4 * 255 + 2);

    // R5 restart mid positive half
    set_div(3); run_tone(3, 1, 4);
    set_div(2); run_tone(2, 1, 8);
    // R5 restart mid negative half
    set_div(1); run_tone(1, 1, 3);
    set_div(2); run_tone(2, 1, 5);

    // R8 pin routing, active then idle
    for (int p = 0; p < (1 << NPIN); p++) begin
      @(negedge clk) pin_out_en = NPIN'(p);
      @(negedge clk);
      chk("R8 active", int'(pin_beep_sel), p);
    end

    // R6 disable: hold until strobe, then zero with mute release
    set_div(5);
    run_tone(5, 1, 12);
    set_div(0);
    chk("R6 hold sample", int'(tone_sample), NEG);
    chk("R6 hold mute", int'(mute_others), 1);
    pulse();
    chk("R6 zero", int'(tone_sample), 0);
    chk("R6 unmute", int'(mute_others), 0);
    for (int p = 0; p < (1 << NPIN); p++) begin
      @(negedge clk) pin_out_en = NPIN'(p);
      @(negedge clk);
      chk("R8 idle", int'(pin_beep_sel), 0);
    end

    // R7 clock stop permission
    @(negedge clk) low_power = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 idle lowpwr", int'(clk_stop_ok), 1);
    set_div(7);
    chk("R7 active lowpwr", int'(clk_stop_ok), 0);
    @(negedge clk) low_power = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 active fullpwr", int'(clk_stop_ok), 1);
    @(negedge clk) low_power = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 relow", int'(clk_stop_ok), 0);
    set_div(0);
    chk("R7 disabled", int'(clk_stop_ok), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule